// File: doc/BRIEF.md
# Extended Bank Register Translator

This block holds the inner bank numbers for an enhanced eight-plus-four register banking scheme and turns the current CPU and PPU addresses into inner bank numbers. The CPU sets it up through two ports in the `$8000-$9FFF` range. A write to the even port picks which register the next data write goes to. The same write also sets two invert flags: one swaps the PRG slots at `$8000` and `$C000`, the other swaps the two 4 KiB halves of pattern space. A write to the odd port stores a byte into the register that was picked.

In classic mode, eight registers are used. PRG bank numbers are six bits wide. Two of the four 8 KiB PRG slots are fixed to the last and second-last banks. The lower pattern half uses two 2 KiB banks. In extended mode, which a neighbouring control block selects through `ext_en`, four more registers come into play. Every 1 KiB pattern slot and every 8 KiB PRG slot then has its own register, and all eight bits of a PRG bank number are used.

Outer-bank combining, interrupt counting and RAM control are handled by other blocks. They take `prg_bank` and `chr_bank` from this block.

Top module: `xbank_xlat`

## Requirements
- R1: A write with `cpu_we` high and `(cpu_addr & 16'hE001) == 16'h8000` loads the select state: target index from `cpu_data[3:0]`, PRG invert from `cpu_data[6]`, pattern invert from `cpu_data[7]`. After reset the select state is index 0 with both inverts clear.
- R2: A write with `(cpu_addr & 16'hE001) == 16'h8001` stores `cpu_data` into the selected register. A write anywhere else, or an access with `cpu_we` low, changes no register and no select state.
- R3: The reset values of registers 0 to 11 are, in order, 00,02,04,05,06,07,00,01,FE,FF,FF,FF (hex).
- R4: In extended mode with the pattern invert clear, the 1 KiB slots at PPU `$0000,$0400,...,$1C00` take their banks from registers 0,10,1,11,2,3,4,5, and `chr_bank` is the full register byte.
- R5: With the pattern invert set, PPU address bit 12 is inverted before the slot lookup, so the two 4 KiB halves trade places in both modes.
- R6: In classic mode, the lower (possibly inverted) 4 KiB half uses 2 KiB banks. The `$0000-$07FF` half takes register 0 and the `$0800-$0FFF` half takes register 1, with bit 0 of the register replaced by PPU address bit 10.
- R7: In extended mode, the PRG slot selected by `cpu_addr[14:13]` (0:`$8000`, 1:`$A000`, 2:`$C000`, 3:`$E000`) takes registers 6,7,8,9 as a full 8-bit number. With the PRG invert set, registers 6 and 8 trade slots.
- R8: In classic mode, PRG slot 1 gives register 7 masked to six bits. Slot 3 gives 3F. Slot 0 gives register 6 masked to six bits and slot 2 gives 3E; with the PRG invert set these two swap.
- R9: In classic mode, registers 8 to 11 have no effect on either output, but they keep the values written to them. Those values take effect once extended mode is on.
- R10: A data write while the selected index is 12 to 15 changes no register.
- R11: A change on `ext_en` changes the outputs at once, with no clock edge and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_en | input | 1 | Extended mode enable from the control block |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 13 | PPU pattern-space address |
| prg_bank | output | 8 | Inner 8 KiB PRG bank for `cpu_addr` |
| chr_bank | output | 8 | Inner 1 KiB pattern bank for `ppu_addr` |

## Verification
The assertions assume `cpu_we` is a clean one-cycle strobe whose address and data are stable at the sampling edge. They also assume `ext_en` is a level from a neighbour that does not need to be synchronous with a write. The stimulus changes every input only on the falling edge. It drops the strobe before a lookup is probed, and it switches `ext_en` only between writes. Each probe therefore sees settled register state and a fixed mode.

// File: rtl/xbank_pkg.sv
package xbank_pkg;
  localparam int NREG  = 12;
  localparam int BYTEW = 8;

  typedef struct packed {
    logic       chr_inv;
    logic       prg_inv;
    logic [3:0] idx;
  } sel_t;

  function automatic logic [7:0] reg_reset_val(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'h02;
      2: return 8'h04;
      3: return 8'h05;
      4: return 8'h06;
      5: return 8'h07;
      6: return 8'h00;
      7: return 8'h01;
      8: return 8'hFE;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [NREG*BYTEW-1:0] all_reset();
    logic [NREG*BYTEW-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*BYTEW +: BYTEW] = reg_reset_val(i);
    return v;
  endfunction

  // register feeding an effective 1 KiB pattern slot (after inversion)
  function automatic logic [3:0] chr_reg_index(input logic [2:0] eslot, input logic ext);
    case (eslot)
      3'd0: return 4'd0;
      3'd1: return ext ? 4'd10 : 4'd0;
      3'd2: return 4'd1;
      3'd3: return ext ? 4'd11 : 4'd1;
      3'd4: return 4'd2;
      3'd5: return 4'd3;
      3'd6: return 4'd4;
      default: return 4'd5;
    endcase
  endfunction

  // register feeding an 8 KiB PRG slot in extended mode
  function automatic logic [3:0] prg_reg_index(input logic [1:0] slot, input logic inv);
    case (slot)
      2'd0: return inv ? 4'd8 : 4'd6;
      2'd1: return 4'd7;
      2'd2: return inv ? 4'd6 : 4'd8;
      default: return 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/xbank_port.sv
module xbank_port
  import xbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_we,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  output logic        sel_wr,
  output logic        data_wr,
  output sel_t        sel_q
);
  logic in_window;
  assign in_window = cpu_we && (cpu_addr[15:13] == 3'b100);
  assign sel_wr    = in_window && !cpu_addr[0];
  assign data_wr   = in_window &&  cpu_addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_wr) begin
      sel_q.chr_inv <= cpu_data[7];
      sel_q.prg_inv <= cpu_data[6];
      sel_q.idx     <= cpu_data[3:0];
    end
  end
endmodule

// File: rtl/xbank_regfile.sv
module xbank_regfile
  import xbank_pkg::*;
#(
  parameter int N = NREG,
  parameter int W = BYTEW,
  localparam int IW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           data_wr,
  input  logic [3:0]     wr_idx,
  input  logic [W-1:0]   wr_data,
  output logic [N*W-1:0] regs_flat
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic hit;
    assign hit = data_wr && (wr_idx == 4'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_flat[g*W +: W] <= W'(reg_reset_val(g));
      else if (hit) regs_flat[g*W +: W] <= wr_data;
    end
  end
endmodule

// File: rtl/xbank_chr_mux.sv
module xbank_chr_mux
  import xbank_pkg::*;
#(
  parameter int N = NREG,
  parameter int W = BYTEW
) (
  input  logic [N*W-1:0] regs_flat,
  input  logic           ext_en,
  input  logic           chr_inv,
  input  logic [12:10]   ppu_hi,
  output logic [W-1:0]   chr_bank
);
  logic [2:0]   eslot;
  logic [3:0]   ridx;
  logic [W-1:0] raw;

  assign eslot = {ppu_hi[12] ^ chr_inv, ppu_hi[11:10]};
  assign ridx  = chr_reg_index(eslot, ext_en);
  assign raw   = regs_flat[ridx*W +: W];

  always_comb begin
    if (!ext_en && !eslot[2]) chr_bank = {raw[W-1:1], ppu_hi[10]};
    else                      chr_bank = raw;
  end
endmodule

// File: rtl/xbank_prg_mux.sv
module xbank_prg_mux
  import xbank_pkg::*;
#(
  parameter int N  = NREG,
  parameter int W  = BYTEW,
  parameter int CW = 6,
  localparam logic [W-1:0] LAST  = W'((1 << CW) - 1),
  localparam logic [W-1:0] NEXT  = W'((1 << CW) - 2),
  localparam logic [W-1:0] CMASK = W'((1 << CW) - 1)
) (
  input  logic [N*W-1:0] regs_flat,
  input  logic           ext_en,
  input  logic           prg_inv,
  input  logic [1:0]     slot,
  output logic [W-1:0]   prg_bank
);
  logic [3:0]   ridx;
  logic [W-1:0] raw;
  logic         fixed_last, fixed_next;

  assign ridx       = prg_reg_index(slot, prg_inv);
  assign raw        = regs_flat[ridx*W +: W];
  assign fixed_last = (slot == 2'd3);
  assign fixed_next = (slot == (prg_inv ? 2'd0 : 2'd2));

  always_comb begin
    if (ext_en)          prg_bank = raw;
    else if (fixed_last) prg_bank = LAST;
    else if (fixed_next) prg_bank = NEXT;
    else                 prg_bank = raw & CMASK;
  end
endmodule

// File: rtl/xbank_xlat.sv
module xbank_xlat
  import xbank_pkg::*;
#(
  parameter int PRG_CLASSIC_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_en,
  input  logic        cpu_we,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic [12:0] ppu_addr,
  output logic [7:0]  prg_bank,
  output logic [7:0]  chr_bank
);
  logic                  sel_wr, data_wr;
  sel_t                  sel_q;
  logic [NREG*BYTEW-1:0] regs_flat;

  xbank_port u_port (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .sel_wr(sel_wr), .data_wr(data_wr), .sel_q(sel_q)
  );

  xbank_regfile #(.N(NREG), .W(BYTEW)) u_regs (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .wr_idx(sel_q.idx),
    .wr_data(cpu_data), .regs_flat(regs_flat)
  );

  xbank_chr_mux #(.N(NREG), .W(BYTEW)) u_chr (
    .regs_flat(regs_flat), .ext_en(ext_en), .chr_inv(sel_q.chr_inv),
    .ppu_hi(ppu_addr[12:10]), .chr_bank(chr_bank)
  );

  xbank_prg_mux #(.N(NREG), .W(BYTEW), .CW(PRG_CLASSIC_W)) u_prg (
    .regs_flat(regs_flat), .ext_en(ext_en), .prg_inv(sel_q.prg_inv),
    .slot(cpu_addr[14:13]), .prg_bank(prg_bank)
  );
endmodule

// File: rtl/xbank_xlat_chk.sv
module xbank_xlat_chk
  import xbank_pkg::*;
#(
  parameter int PRG_CLASSIC_W = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ext_en,
  input logic [15:0]           cpu_addr,
  input logic [7:0]            cpu_data,
  input logic [12:0]           ppu_addr,
  input logic [7:0]            prg_bank,
  input logic [7:0]            chr_bank,
  input logic                  sel_wr,
  input logic                  data_wr,
  input sel_t                  sel_q,
  input logic [NREG*BYTEW-1:0] regs_flat
);
  logic       exp_vld;
  logic [3:0] exp_idx;
  logic [7:0] exp_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_vld <= 1'b0;
      exp_idx <= '0;
      exp_dat <= '0;
    end else begin
      exp_vld <= data_wr && (sel_q.idx < 4'(NREG));
      exp_idx <= sel_q.idx;
      exp_dat <= cpu_data;
    end
  end

  a_r1_sel_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (sel_q.idx == $past(cpu_data[3:0]) && sel_q.prg_inv == $past(cpu_data[6])
                && sel_q.chr_inv == $past(cpu_data[7])));

  a_r2_data_store: assert property (@(posedge clk) disable iff (!rst_n)
    exp_vld |-> regs_flat[exp_idx*BYTEW +: BYTEW] == exp_dat);

  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(regs_flat));

  a_r10_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && sel_q.idx >= 4'(NREG)) |=> $stable(regs_flat));

  a_r3_reset_vals: assert property (@(posedge clk)
    $rose(rst_n) |-> regs_flat == all_reset());

  a_r8_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && cpu_addr[14:13] == 2'b11) |-> prg_bank == 8'((1 << PRG_CLASSIC_W) - 1));

  a_r6_a10_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && ppu_addr[12] == sel_q.chr_inv) |-> chr_bank[0] == ppu_addr[10]);
endmodule

bind xbank_xlat xbank_xlat_chk #(.PRG_CLASSIC_W(PRG_CLASSIC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
  .ppu_addr(ppu_addr), .prg_bank(prg_bank), .chr_bank(chr_bank), .sel_wr(sel_wr),
  .data_wr(data_wr), .sel_q(sel_q), .regs_flat(regs_flat)
);

// File: tb/xbank_xlat_test.sv
module xbank_xlat_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_en = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [12:0] ppu_addr = '0;
  logic [7:0]  prg_bank, chr_bank;

  always #2 clk = ~clk;

  xbank_xlat uut (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .ppu_addr(ppu_addr), .prg_bank(prg_bank), .chr_bank(chr_bank)
  );

  typedef struct {
    logic [7:0] ep;
    logic [7:0] ec;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic [7:0] m [0:11];
  logic [3:0] m_sel;
  logic       m_pinv, m_cinv;

  task automatic model_reset();
    m[0] = 8'h00; m[1] = 8'h02; m[2] = 8'h04; m[3] = 8'h05;
    m[4] = 8'h06; m[5] = 8'h07; m[6] = 8'h00; m[7] = 8'h01;
    m[8] = 8'hFE; m[9] = 8'hFF; m[10] = 8'hFF; m[11] = 8'hFF;
    m_sel = 0; m_pinv = 0; m_cinv = 0;
  endtask

  function automatic logic [7:0] xp(input logic [15:0] a);
    logic [1:0] s = a[14:13];
    if (ext_en) begin
      case (s)
        0: return m_pinv ? m[8] : m[6];
        1: return m[7];
        2: return m_pinv ? m[6] : m[8];
        default: return m[9];
      endcase
    end
    case (s)
      0: return m_pinv ? 8'd62 : (m[6] & 8'h3F);
      1: return m[7] & 8'h3F;
      2: return m_pinv ? (m[6] & 8'h3F) : 8'd62;
      default: return 8'd63;
    endcase
  endfunction

  function automatic logic [7:0] xc(input logic [12:0] p);
    logic [12:0] v = m_cinv ? (p ^ 13'h1000) : p;
    if (!ext_en && v < 13'h0800) return {m[0][7:1], p[10]};
    if (!ext_en && v < 13'h1000) return {m[1][7:1], p[10]};
    if (v < 13'h0400) return m[0];
    if (v < 13'h0800) return m[10];
    if (v < 13'h0C00) return m[1];
    if (v < 13'h1000) return m[11];
    if (v < 13'h1400) return m[2];
    if (v < 13'h1800) return m[3];
    if (v < 13'h1C00) return m[4];
    return m[5];
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic we = 1'b1);
    @(negedge clk);
    cpu_we = we; cpu_addr = a; cpu_data = d;
    if (we && (a & 16'hE001) == 16'h8000) begin
      m_sel = d[3:0]; m_pinv = d[6]; m_cinv = d[7];
    end else if (we && (a & 16'hE001) == 16'h8001 && m_sel < 12) begin
      m[m_sel] = d;
    end
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a, input logic [12:0] p, input string tag);
    item_t it;
    @(negedge clk);
    cpu_we = 1'b0; cpu_addr = a; ppu_addr = p;
    it.ep = xp(a); it.ec = xc(p); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic probe_all(input string tag);
    for (int i = 0; i < 8; i++)
      probe(16'h8000 + 16'(i % 4) * 16'h2000 + 16'h0123, 13'(i) * 13'h0400 + 13'h0011, tag);
  endtask

  // monitor
  always begin
    item_t it;
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (prg_bank !== it.ep) begin
        errors++;
        $display("FAIL %s prg cpu=%h actual=%h expected=%h", it.tag, cpu_addr, prg_bank, it.ep);
      end
      if (chr_bank !== it.ec) begin
        errors++;
        $display("FAIL %s chr ppu=%h actual=%h expected=%h", it.tag, ppu_addr, chr_bank, it.ec);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL R0 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    probe_all("R3 R8 R6 reset classic");
    @(negedge clk); ext_en = 1'b1;
    probe_all("R3 R4 R7 R11 reset extended");

    wr(16'h8000, 8'h06); wr(16'h8001, 8'hC5);
    probe_all("R1 R2 R7 ext 8-bit prg");
    @(negedge clk); ext_en = 1'b0;
    probe_all("R8 R11 classic mask");

    wr(16'h9FFE, 8'h46); wr(16'h9FFF, 8'h12);
    probe_all("R8 R1 classic prg invert");
    @(negedge clk); ext_en = 1'b1;
    probe_all("R7 ext prg invert");
    @(negedge clk); ext_en = 1'b0;

    wr(16'h8000, 8'h09); wr(16'h8001, 8'h80);
    wr(16'h8000, 8'h0A); wr(16'h8001, 8'h33);
    wr(16'h8000, 8'h0B); wr(16'h8001, 8'h44);
    wr(16'h8000, 8'h00); wr(16'h8001, 8'h21);
    wr(16'h8000, 8'h01); wr(16'h8001, 8'h57);
    wr(16'h8000, 8'h02); wr(16'h8001, 8'h9A);
    probe_all("R9 R6 classic ignores 8-11");
    @(negedge clk); ext_en = 1'b1;
    probe_all("R9 R4 extended uses 8-11");

    wr(16'h8000, 8'h85);
    probe_all("R5 ext chr invert");
    @(negedge clk); ext_en = 1'b0;
    probe_all("R5 R6 classic chr invert");

    wr(16'h8000, 8'h0C); wr(16'h8001, 8'h99);
    wr(16'h8000, 8'h0F); wr(16'h8001, 8'h77);
    probe_all("R10 bad index classic");
    @(negedge clk); ext_en = 1'b1;
    probe_all("R10 bad index extended");

    wr(16'h8000, 8'h07);
    wr(16'hA001, 8'h3C); wr(16'hC001, 8'h3D); wr(16'hE001, 8'h3E);
    wr(16'hA000, 8'hC8); wr(16'h7FFF, 8'h11);
    wr(16'h8001, 8'h5A, 1'b0);
    probe_all("R2 R1 foreign writes ignored");
    wr(16'h8001, 8'hE7);
    probe_all("R2 store after ignored writes");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule